// File: doc/BRIEF.md
# Display Controller Control Register Bank

This block is the software-visible control register bank of a scan-out display controller. A host reaches five 32-bit registers over a simple word-wide register bus. Each register has three addresses: a plain write, an alias that ORs the written one bits into the register, and an alias that clears them. Set and clear let software change one bit without a read-modify-write.

Two inputs come back from the pixel datapath. A frame-start strobe marks the vertical sync, and a FIFO-empty flag shows that the pixel FIFO has drained. The bank uses the strobe to move a pending frame-buffer base address into the active base address at the frame boundary, so a pan never tears. It uses the flag to keep the run bit set after scanning is turned off, until the FIFO holds no more data. A soft-reset bit holds the whole bank at zero until software releases it.

Top module: `dcr_regbank`

## Requirements
- R1: A write to a register's base offset (address bits 3:2 = 0) replaces its writable bits with the written data. Bits that are not writable read as 0.
- R2: A write to base + 0x4 (bits 3:2 = 1) ORs the written one bits into the register and leaves the other bits unchanged.
- R3: A write to base + 0x8 (bits 3:2 = 2) clears the written one bits and leaves the other bits unchanged.
- R4: Registers sit at a 0x10 stride and all reset to 0.
  - Main control at 0x00: soft reset is bit 31, clock gate bit 30, scan mode bit 17, run bit 0.
  - Auxiliary control at 0x10: FIFO flush is bit 21, a 4-bit byte-lane mask is bits 19:16.
  - Transfer size at 0x20: line count in bits 31:16, pixels per line in bits 15:0.
  - Active base at 0x30.
  - Pending base at 0x40.
- R5: The active base ignores bus writes. It is loaded with the pending base only in the cycle after `frame_start` is high; otherwise it holds.
- R6: While scan mode is 0 and run is 1, run stays 1 as long as `fifo_empty` is low. In the cycle after `fifo_empty` is seen high, run clears by itself.
- R7: While soft reset is 1, every other bit of every register is held at 0 and bus writes to them have no effect. Soft reset itself reads 1 until software clears it.
- R8: Reads at the set and clear aliases return the same value as the base offset.
- R9: Unmapped offsets are ignored on write and read as 0. These are a register index of 5 or more, or an address whose bits 3:2 are 3.
- R10: The output ports carry the current register fields: `run`, `scan_mode`, `clk_gate`, `soft_reset`, `fifo_flush`, `lane_mask`, `line_count`, `line_pixels` and `cur_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| frame_start | input | 1 | Vertical-sync strobe from the datapath |
| fifo_empty | input | 1 | Pixel FIFO holds no data |
| soft_reset | output | 1 | Soft reset bit |
| clk_gate | output | 1 | Clock gate bit |
| scan_mode | output | 1 | Scan mode enable |
| run | output | 1 | Run bit |
| fifo_flush | output | 1 | FIFO flush bit |
| lane_mask | output | 4 | Byte-lane mask |
| line_count | output | 16 | Lines per frame |
| line_pixels | output | 16 | Pixels per line |
| cur_base | output | 32 | Active frame-buffer base address |

## Verification
The bench builds the bank with the default `ADDR_W` of 8. That makes all sixteen 0x10 slots addressable, including indices 5 to 15 and the fourth alias slot of each register, so the unmapped-write and unmapped-read rules of R9 can be reached. With that width, every alias of every register, the drain of the run bit against the FIFO flag, a pan across two frame strobes and a full soft-reset hold are all driven through the bus. Each is compared against values worked out from the register map.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    localparam int DW         = 32;
    localparam int NUM_REGS   = 5;
    localparam int STRIDE_LSB = 4;

    localparam int REG_CTRL = 0;
    localparam int REG_AUX  = 1;
    localparam int REG_XFER = 2;
    localparam int REG_CUR  = 3;
    localparam int REG_NXT  = 4;

    localparam int CTRL_SRST_BIT = 31;
    localparam int CTRL_GATE_BIT = 30;
    localparam int CTRL_SCAN_BIT = 17;
    localparam int CTRL_RUN_BIT  = 0;
    localparam int AUX_FLUSH_BIT = 21;
    localparam int AUX_LANE_LSB  = 16;
    localparam int LANE_W        = 4;
    localparam int HALF_W        = DW / 2;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [1:0] {
        OP_PLAIN = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef struct packed {
        word_t [NUM_REGS-1:0] r;
    } bank_t;

    function automatic word_t wmask(input int idx);
        word_t m;
        m = '0;
        case (idx)
            REG_CTRL: begin
                m[CTRL_SRST_BIT] = 1'b1;
                m[CTRL_GATE_BIT] = 1'b1;
                m[CTRL_SCAN_BIT] = 1'b1;
                m[CTRL_RUN_BIT]  = 1'b1;
            end
            REG_AUX: begin
                m[AUX_FLUSH_BIT] = 1'b1;
                m[AUX_LANE_LSB +: LANE_W] = '1;
            end
            REG_XFER: m = '1;
            REG_NXT:  m = '1;
            default:  m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
    import dcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [NUM_REGS-1:0] sel_o,
    output op_e                 op_o
);
    localparam int IDX_W = ADDR_W - STRIDE_LSB;

    logic [IDX_W-1:0] idx;
    logic [1:0]       alias_f;
    logic             mapped;

    assign idx     = addr_i[ADDR_W-1:STRIDE_LSB];
    assign alias_f = addr_i[STRIDE_LSB-1:2];
    assign mapped  = (idx < IDX_W'(NUM_REGS)) && (alias_f != 2'd3);
    assign op_o    = op_e'(alias_f);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign sel_o[i] = mapped && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/dcr_field_update.sv
module dcr_field_update
    import dcr_pkg::*;
#(
    parameter word_t MASK = '0
) (
    input  word_t cur_i,
    input  word_t wdata_i,
    input  op_e   op_i,
    input  logic  en_i,
    output word_t nxt_o
);
    word_t wm;

    assign wm = wdata_i & MASK;

    always_comb begin
        nxt_o = cur_i;
        if (en_i) begin
            case (op_i)
                OP_PLAIN: nxt_o = (cur_i & ~MASK) | wm;
                OP_SET:   nxt_o = cur_i | wm;
                OP_CLR:   nxt_o = cur_i & ~wm;
                default:  nxt_o = cur_i;
            endcase
        end
    end
endmodule

// File: rtl/dcr_regbank.sv
module dcr_regbank
    import dcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              frame_start,
    input  logic              fifo_empty,
    output logic              soft_reset,
    output logic              clk_gate,
    output logic              scan_mode,
    output logic              run,
    output logic              fifo_flush,
    output logic [3:0]        lane_mask,
    output logic [15:0]       line_count,
    output logic [15:0]       line_pixels,
    output logic [31:0]       cur_base
);
    bank_t                bank_d, bank_q;
    logic [NUM_REGS-1:0]  sel;
    op_e                  op;
    word_t [NUM_REGS-1:0] sw_next;
    word_t                nxt_base_q;

    dcr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (bus_addr),
        .sel_o  (sel),
        .op_o   (op)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        dcr_field_update #(.MASK(wmask(i))) u_upd (
            .cur_i   (bank_q.r[i]),
            .wdata_i (bus_wdata),
            .op_i    (op),
            .en_i    (bus_we && sel[i]),
            .nxt_o   (sw_next[i])
        );
    end

    // Next-state: bus update, then drain, frame load, soft reset (highest)
    always_comb begin
        bank_d.r = sw_next;
        if (bank_q.r[REG_CTRL][CTRL_RUN_BIT] && !bank_q.r[REG_CTRL][CTRL_SCAN_BIT]
            && fifo_empty) begin
            bank_d.r[REG_CTRL][CTRL_RUN_BIT] = 1'b0;
        end
        if (frame_start) begin
            bank_d.r[REG_CUR] = bank_q.r[REG_NXT];
        end
        if (bank_d.r[REG_CTRL][CTRL_SRST_BIT]) begin
            bank_d.r = '0;
            bank_d.r[REG_CTRL][CTRL_SRST_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) begin
                bus_rdata = bus_rdata | bank_q.r[i];
            end
        end
    end

    assign soft_reset  = bank_q.r[REG_CTRL][CTRL_SRST_BIT];
    assign clk_gate    = bank_q.r[REG_CTRL][CTRL_GATE_BIT];
    assign scan_mode   = bank_q.r[REG_CTRL][CTRL_SCAN_BIT];
    assign run         = bank_q.r[REG_CTRL][CTRL_RUN_BIT];
    assign fifo_flush  = bank_q.r[REG_AUX][AUX_FLUSH_BIT];
    assign lane_mask   = bank_q.r[REG_AUX][AUX_LANE_LSB +: LANE_W];
    assign line_count  = bank_q.r[REG_XFER][DW-1:HALF_W];
    assign line_pixels = bank_q.r[REG_XFER][HALF_W-1:0];
    assign cur_base    = bank_q.r[REG_CUR];
    assign nxt_base_q  = bank_q.r[REG_NXT];
endmodule

// File: rtl/dcr_regbank_chk.sv
module dcr_regbank_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_rdata,
    input logic              frame_start,
    input logic              fifo_empty,
    input logic              soft_reset,
    input logic              scan_mode,
    input logic              run,
    input logic [15:0]       line_count,
    input logic [31:0]       cur_base,
    input logic [31:0]       nxt_base
);
    logic unmapped;
    assign unmapped = (bus_addr[ADDR_W-1:4] >= (ADDR_W-4)'(5)) || (bus_addr[3:2] == 2'd3);

    AST_PAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !bus_we) |=> $stable(cur_base)); // R5
    AST_PAN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !bus_we && !soft_reset) |=> (cur_base == $past(nxt_base))); // R5
    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !scan_mode && !fifo_empty && !bus_we) |=> run); // R6
    AST_RUN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !scan_mode && fifo_empty) |=> !run); // R6
    AST_SRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |-> (!run && !scan_mode && cur_base == '0 && line_count == '0)); // R7
    AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (bus_rdata == '0)); // R9
endmodule

bind dcr_regbank dcr_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_rdata   (bus_rdata),
    .frame_start (frame_start),
    .fifo_empty  (fifo_empty),
    .soft_reset  (soft_reset),
    .scan_mode   (scan_mode),
    .run         (run),
    .line_count  (line_count),
    .cur_base    (cur_base),
    .nxt_base    (nxt_base_q)
);

// File: tb/test_dcr_regbank.sv
module test_dcr_regbank;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              frame_start = 1'b0;
    logic              fifo_empty = 1'b0;
    logic              soft_reset, clk_gate, scan_mode, run, fifo_flush;
    logic [3:0]        lane_mask;
    logic [15:0]       line_count, line_pixels;
    logic [31:0]       cur_base;

    int total = 0;
    int fails = 0;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [31:0]       exp;
        string             tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    always #5 clk = ~clk;

    dcr_regbank #(.ADDR_W(ADDR_W)) i_dcr_regbank (
        .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
        .frame_start, .fifo_empty, .soft_reset, .clk_gate, .scan_mode,
        .run, .fifo_flush, .lane_mask, .line_count, .line_pixels, .cur_base
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    // Driver: push expected read value; monitor compares it
    task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
        rd_item_t it;
        @(negedge clk);
        bus_addr = a;
        it.addr = a;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic settle();
        @(negedge clk);
        #3;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // Monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                rd_item_t it;
                it = sb_q.pop_front();
                chk($sformatf("%s rd@0x%02h", it.tag, it.addr), bus_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4 reset values
        settle();
        chk("R4 reset run", {31'd0, run}, 32'd0);
        chk("R4 reset cur_base", cur_base, 32'd0);
        rd(8'h00, 32'h0, "R4 reset ctrl");
        rd(8'h40, 32'h0, "R4 reset next");

        // R1 plain write; R10 ports
        wr(8'h00, 32'h0002_0001);
        rd(8'h00, 32'h0002_0001, "R1 plain write");
        settle();
        chk("R10 run port", {31'd0, run}, 32'd1);
        chk("R10 scan port", {31'd0, scan_mode}, 32'd1);
        wr(8'h00, 32'h7FFD_FFFE);
        rd(8'h00, 32'h4000_0000, "R1 unwritable bits zero");

        // R2 set alias, R3 clear alias, R8 alias reads
        wr(8'h04, 32'h0002_0001);
        rd(8'h00, 32'h4002_0001, "R2 set alias");
        wr(8'h08, 32'h4000_0000);
        rd(8'h00, 32'h0002_0001, "R3 clear alias");
        rd(8'h04, 32'h0002_0001, "R8 set alias read");
        rd(8'h08, 32'h0002_0001, "R8 clear alias read");
        settle();
        chk("R10 clk_gate port", {31'd0, clk_gate}, 32'd0);

        // Aux register R4/R3/R10
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h002F_0000, "R4 aux fields");
        wr(8'h18, 32'h0005_0000);
        rd(8'h10, 32'h002A_0000, "R3 aux clear");
        settle();
        chk("R10 lane_mask", {28'd0, lane_mask}, 32'hA);
        chk("R10 fifo_flush", {31'd0, fifo_flush}, 32'd1);

        // Transfer size R4/R10
        wr(8'h20, 32'h01E0_0320);
        rd(8'h20, 32'h01E0_0320, "R4 xfer");
        settle();
        chk("R10 line_count", {16'd0, line_count}, 32'h1E0);
        chk("R10 line_pixels", {16'd0, line_pixels}, 32'h320);

        // R5 pan at frame boundary
        wr(8'h30, 32'h0000_1234);
        rd(8'h30, 32'h0, "R5 active base ignores writes");
        wr(8'h40, 32'h8000_1000);
        rd(8'h40, 32'h8000_1000, "R5 pending base");
        repeat (3) settle();
        chk("R5 no load without frame", cur_base, 32'h0);
        frame();
        settle();
        chk("R5 load at frame", cur_base, 32'h8000_1000);
        wr(8'h40, 32'h8000_2000);
        wr(8'h44, 32'h0000_0001);
        rd(8'h40, 32'h8000_2001, "R2 pending set alias");
        settle();
        chk("R5 hold before second frame", cur_base, 32'h8000_1000);
        frame();
        rd(8'h30, 32'h8000_2001, "R5 second frame load");

        // R9 unmapped
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h50, 32'h0, "R9 unmapped index read");
        rd(8'h0C, 32'h0, "R9 fourth alias read");
        rd(8'hF0, 32'h0, "R9 top slot read");
        rd(8'h00, 32'h0002_0001, "R9 ctrl untouched");
        rd(8'h10, 32'h002A_0000, "R9 aux untouched");

        // R6 drain
        wr(8'h08, 32'h0002_0000);
        repeat (4) settle();
        chk("R6 run held while FIFO busy", {31'd0, run}, 32'd1);
        rd(8'h00, 32'h0000_0001, "R6 ctrl during drain");
        @(negedge clk);
        fifo_empty = 1'b1;
        settle();
        chk("R6 run clears when FIFO empty", {31'd0, run}, 32'd0);
        rd(8'h00, 32'h0, "R6 ctrl after drain");
        @(negedge clk);
        fifo_empty = 1'b0;

        // R7 soft reset
        wr(8'h04, 32'h0002_0001);
        wr(8'h04, 32'h8000_0000);
        rd(8'h00, 32'h8000_0000, "R7 ctrl under soft reset");
        rd(8'h10, 32'h0, "R7 aux cleared");
        rd(8'h20, 32'h0, "R7 xfer cleared");
        rd(8'h40, 32'h0, "R7 next cleared");
        settle();
        chk("R7 soft_reset port", {31'd0, soft_reset}, 32'd1);
        chk("R7 cur_base cleared", cur_base, 32'h0);
        wr(8'h20, 32'h1111_2222);
        rd(8'h20, 32'h0, "R7 write blocked");
        frame();
        settle();
        chk("R7 frame blocked", cur_base, 32'h0);
        wr(8'h08, 32'h8000_0000);
        rd(8'h00, 32'h0, "R7 released");
        wr(8'h20, 32'h0010_0020);
        rd(8'h20, 32'h0010_0020, "R7 write after release");

        repeat (3) settle();
        summary();
        $finish;
    end
endmodule